// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page mappings for an address path. Each cycle in which the requester presents a virtual page number, every stored entry is compared with it at once. When a valid entry matches, the physical page number comes back combinationally in that same cycle, so the data access needs no extra page-table read. When nothing matches, the block records the missing page number and raises a walk request. The page-table fetch is done outside the block. The walker later delivers the mapping through the fill port, and the block writes it into a slot it selects.

A small controller has two states. In `ST_LOOKUP` lookups are accepted. The transition `miss_taken` moves the controller to `ST_AWAIT_FILL` when an accepted lookup misses. In `ST_AWAIT_FILL` the walk request is held and lookups are refused. The transition `fill_seen` returns the controller to `ST_LOOKUP` when a fill arrives. A flush input invalidates every entry in a single cycle, for example on a context switch. Hit and miss counters let software work out the effective access time, 2 + ε − α memory cycles, where α is the measured hit ratio.

Top module: `tlb_fa`

## Requirements
- R1: In `ST_LOOKUP`, a lookup whose VPN equals the VPN of a valid entry raises `lkp_hit` in the same cycle, and `lkp_ppn` carries that entry's PPN.
- R2: An accepted lookup that misses moves the controller to `ST_AWAIT_FILL` on the next cycle. While in that state, `walk_req` is 1, `walk_vpn` holds the missed VPN and `lkp_ready` is 0, so lookups are neither answered nor counted.
- R3: A fill is written in either state. A fill in `ST_AWAIT_FILL` returns the controller to `ST_LOOKUP` on the next cycle.
- R4: A fill for a VPN that is not present is written to the lowest-numbered invalid slot.
- R5: When all slots are valid, a fill for a new VPN replaces the slot named by a victim pointer. The pointer is 0 after reset and advances by one, wrapping from the last slot to slot 0, after each such replacement.
- R6: A fill whose VPN matches a valid entry overwrites that entry's PPN in place. No other slot changes, the victim pointer does not move, and no VPN is ever held twice.
- R7: `flush` invalidates every entry at the next clock edge. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is discarded, although it still completes a pending walk.
- R8: A lookup and a fill in the same cycle: the lookup sees the table as it was before the fill.
- R9: `hit_count` increments once for each accepted lookup that hits, and `miss_count` increments once for each accepted lookup that misses. Both become visible on the cycle after the lookup.
- R10: After reset all entries are invalid, the controller is in `ST_LOOKUP` and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W | Virtual page number to translate |
| lkp_ready | output | 1 | Lookups accepted (controller in `ST_LOOKUP`) |
| lkp_hit | output | 1 | Accepted lookup found a valid match |
| lkp_ppn | output | PPN_W | Physical page number of the match (zero when no match) |
| walk_req | output | 1 | Page-table fetch requested |
| walk_vpn | output | VPN_W | Page number that missed |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_vpn | input | VPN_W | Virtual page number being filled |
| fill_ppn | input | PPN_W | Physical page number being filled |
| flush | input | 1 | Invalidate all entries |
| hit_count | output | CNT_W | Accepted lookups that hit |
| miss_count | output | CNT_W | Accepted lookups that missed |

## Verification
Two operations can fall in the same cycle. A lookup can coincide with a fill, and a lookup or fill can coincide with a flush. The bench provokes both pairings directly: a lookup of a VPN together with a fill of that same VPN, a lookup of a new VPN together with its own fill, and a flush together with a lookup of a resident page and a fill. A randomized phase with a narrow VPN range then makes these overlaps frequent. A behavioural model, holding arrays, a pointer integer and a state flag, is compared with the outputs in every cycle. It judges each overlap by the rules that a lookup sees the table before any write in that cycle and that a flush overrides both the hit and the write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP     = 1'b0,
        ST_AWAIT_FILL = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   srch_vpn,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PPN_W-1:0]   wr_ppn,
    output logic [ENTRIES-1:0] srch_match,
    output logic [ENTRIES-1:0] fill_match,
    output logic [ENTRIES-1:0] valid_vec,
    output logic [PPN_W-1:0]   hit_ppn
);
    logic [VPN_W-1:0] vpn_q [ENTRIES];
    logic [PPN_W-1:0] ppn_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_vec[g] <= 1'b0;
                vpn_q[g]     <= '0;
                ppn_q[g]     <= '0;
            end else if (flush) begin
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_vec[g] <= 1'b1;
                vpn_q[g]     <= fill_vpn;
                ppn_q[g]     <= wr_ppn;
            end
        end
        assign srch_match[g] = valid_vec[g] && (vpn_q[g] == srch_vpn);
        assign fill_match[g] = valid_vec[g] && (vpn_q[g] == fill_vpn);
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (srch_match[i]) hit_ppn |= ppn_q[i];
    end

    // R6
    no_dup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(srch_match));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_go,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] fill_match,
    output logic [IDX_W-1:0]   wr_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;
    logic             replace;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fill_match[i]) match_idx = IDX_W'(i);
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign any_match = |fill_match;
    assign any_free  = ~&valid_vec;
    assign replace   = fill_go && !any_match && !any_free;

    always_comb begin
        if (any_match)     wr_idx = match_idx;
        else if (any_free) wr_idx = free_idx;
        else               wr_idx = rr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rr_q <= '0;
        else if (replace) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end

    // R5
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replace |=> (rr_q != $past(rr_q)));

    // R6
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_go && any_match) |=> $stable(rr_q));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic [VPN_W-1:0] lkp_vpn,
    input  logic             hit_raw,
    input  logic             fill_valid,
    output logic             lkp_ready,
    output logic             lkp_hit,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    tlb_state_e state_q, state_d;
    logic       miss_taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:     if (lkp_valid && !hit_raw) state_d = ST_AWAIT_FILL;
            ST_AWAIT_FILL: if (fill_valid)            state_d = ST_LOOKUP;
            default:       state_d = ST_LOOKUP;
        endcase
    end

    always_comb begin
        lkp_ready = (state_q == ST_LOOKUP);
        walk_req  = (state_q == ST_AWAIT_FILL);
        lkp_hit   = lkp_ready && lkp_valid && hit_raw;
    end

    assign miss_taken = lkp_ready && lkp_valid && !hit_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_vpn   <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (lkp_hit) hit_count <= hit_count + CNT_W'(1);
            if (miss_taken) begin
                miss_count <= miss_count + CNT_W'(1);
                walk_vpn   <= lkp_vpn;
            end
        end
    end

    // R2
    miss_to_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_taken |=> (walk_req && walk_vpn == $past(lkp_vpn)));

    // R3
    fill_to_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && fill_valid) |=> lkp_ready);

    // R9
    hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |=> (hit_count == $past(hit_count) + CNT_W'(1) && $stable(miss_count)));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 12,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic [VPN_W-1:0] lkp_vpn,
    output logic             lkp_ready,
    output logic             lkp_hit,
    output logic [PPN_W-1:0] lkp_ppn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] srch_match;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   wr_idx;
    logic               fill_go;
    logic               hit_raw;

    assign fill_go = fill_valid && !flush;
    assign hit_raw = (|srch_match) && !flush;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .srch_vpn   (lkp_vpn),
        .fill_vpn   (fill_vpn),
        .wr_en      (fill_go),
        .wr_idx     (wr_idx),
        .wr_ppn     (fill_ppn),
        .srch_match (srch_match),
        .fill_match (fill_match),
        .valid_vec  (valid_vec),
        .hit_ppn    (lkp_ppn)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_go    (fill_go),
        .valid_vec  (valid_vec),
        .fill_match (fill_match),
        .wr_idx     (wr_idx)
    );

    tlb_ctrl #(.VPN_W(VPN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lkp_valid  (lkp_valid),
        .lkp_vpn    (lkp_vpn),
        .hit_raw    (hit_raw),
        .fill_valid (fill_valid),
        .lkp_ready  (lkp_ready),
        .lkp_hit    (lkp_hit),
        .walk_req   (walk_req),
        .walk_vpn   (walk_vpn),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // R7
    flush_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !lkp_hit);
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [19:0] lkp_vpn = '0;
    logic        lkp_ready, lkp_hit, walk_req;
    logic [11:0] lkp_ppn;
    logic [19:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [11:0] fill_ppn = '0;
    logic        flush = 1'b0;
    logic [15:0] hit_count, miss_count;

    always #10 clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn),
        .lkp_ready(lkp_ready), .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn),
        .walk_req(walk_req), .walk_vpn(walk_vpn), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .flush(flush),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_val [N];
    logic [19:0] m_vpn [N];
    logic [11:0] m_ppn [N];
    int          m_rr = 0;
    bit          m_wait = 0;
    logic [19:0] m_wvpn = '0;
    int          m_hits = 0;
    int          m_miss = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit lv, input logic [19:0] lvpn, input bit fv,
                        input logic [19:0] fvpn, input logic [11:0] fppn, input bit fl);
        int hidx;
        bit hit_e;
        string tag;
        @(negedge clk);
        lkp_valid = lv; lkp_vpn = lvpn; fill_valid = fv;
        fill_vpn = fvpn; fill_ppn = fppn; flush = fl;
        #2;
        hidx = -1;
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_vpn[i] == lvpn) hidx = i;
        hit_e = !m_wait && lv && hidx >= 0 && !fl;
        tag = fl ? "R7" : (fv ? "R8" : "R1");
        chk(lkp_ready, !m_wait, "R2 ready");
        chk(lkp_hit, hit_e, tag);
        if (hit_e) chk(lkp_ppn, m_ppn[hidx], tag);
        chk(walk_req, m_wait, "R3 walk_req");
        if (m_wait) chk(walk_vpn, m_wvpn, "R2 walk_vpn");
        chk(hit_count, m_hits[15:0], "R9 hits");
        chk(miss_count, m_miss[15:0], "R9 misses");
        @(posedge clk);
        // reference update, using pre-edge state
        if (!m_wait && lv) begin
            if (hit_e) m_hits++;
            else begin m_miss++; m_wait = 1; m_wvpn = lvpn; end
        end else if (m_wait && fv) m_wait = 0;
        if (fl) begin
            for (int i = 0; i < N; i++) m_val[i] = 0;
        end else if (fv) begin
            int tgt;
            tgt = -1;
            for (int i = 0; i < N; i++)
                if (m_val[i] && m_vpn[i] == fvpn) tgt = i;          // R6
            if (tgt < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_val[i]) tgt = i; // R4
            if (tgt < 0) begin tgt = m_rr; m_rr = (m_rr + 1) % N; end  // R5
            m_val[tgt] = 1; m_vpn[tgt] = fvpn; m_ppn[tgt] = fppn;
        end
    endtask

    task automatic idle();
        step(0, '0, 0, '0, '0, 0);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R10: reset state
        chk(lkp_ready, 1, "R10 ready");
        chk(walk_req, 0, "R10 walk_req");
        chk(hit_count, 0, "R10 hits");
        chk(miss_count, 0, "R10 misses");
        step(1, 20'd5, 0, '0, '0, 0);            // R10: empty table misses
        // R2: walk request holds vpn; lookups refused
        step(1, 20'd5, 0, '0, '0, 0);
        step(0, '0, 1, 20'd5, 12'h105, 0);       // R3 fill returns to lookup
        step(1, 20'd5, 0, '0, '0, 0);            // R1 hit
        for (int v = 10; v < 17; v++)            // R4 fill free slots
            step(0, '0, 1, 20'(v), 12'(12'h200 + v), 0);
        for (int v = 10; v < 17; v++)
            step(1, 20'(v), 0, '0, '0, 0);
        step(0, '0, 1, 20'd5, 12'h777, 0);       // R6 in-place update
        step(1, 20'd5, 0, '0, '0, 0);
        step(0, '0, 1, 20'd30, 12'h030, 0);      // R5 replaces slot 0
        step(1, 20'd5, 0, '0, '0, 0);
        step(0, '0, 1, 20'd31, 12'h031, 0);      // R5 replaces slot 1
        step(1, 20'd10, 0, '0, '0, 0);
        step(0, '0, 1, 20'd10, 12'h010, 0);
        step(1, 20'd12, 1, 20'd12, 12'h0cc, 0);  // R8 lookup sees old ppn
        step(1, 20'd12, 0, '0, '0, 0);
        step(1, 20'd40, 1, 20'd40, 12'h040, 0);  // R8 miss despite own fill
        step(0, '0, 1, 20'd40, 12'h040, 0);
        step(1, 20'd40, 0, '0, '0, 0);
        step(1, 20'd13, 1, 20'd50, 12'h050, 1);  // R7 flush wins
        step(0, '0, 1, 20'd13, 12'h013, 0);
        step(1, 20'd14, 0, '0, '0, 0);
        step(0, '0, 1, 20'd14, 12'h014, 0);
        step(1, 20'd13, 0, '0, '0, 0);
        idle();
        for (int k = 0; k < 600; k++) begin       // R1..R9 mixed traffic
            int r;
            r = $urandom_range(0, 99);
            step($urandom_range(0, 1) == 1, 20'($urandom_range(0, 11)),
                 $urandom_range(0, 2) != 0, 20'($urandom_range(0, 11)),
                 12'($urandom_range(0, 4095)), r < 4);
        end
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule